// File: doc/BRIEF.md
# Serial Combination Lock

This block watches a single serial bit stream, taking one bit on each rising clock edge, and raises its unlock output whenever the four most recent bits it has taken are 0, 1, 1, 0 in that order of arrival. It is a Moore machine with five states. After a wrong bit it falls back to the longest tail of the received bits that could still begin the code, so codes that overlap are all recognised. A 16-location lookup table chooses the next state and the output. Each location is addressed by the current input bit placed above the three state bits, and it holds the three next-state bits above the unlock bit.

The input may come from outside the clock domain. In that case the parameter `USE_SYNC` places a two-flop synchronizer ahead of the state logic, which adds two cycles of latency. With `USE_SYNC` = 0 the input must already be synchronous and is used directly. Reset is synchronous and active low. The three state codes that are never used lead back to the initial state on the next edge and keep unlock at 0.

Top module: `combo_lock_fsm`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, the machine loads the initial state (code 000), unlock reads 0 on the following cycle, and `bit_in` has no effect. A code entry that a reset interrupts does not finish after release. The state register only ever holds one of the codes 000, 001, 011, 010, 100.
- R2: `unlock` is 1 for exactly the cycle after the state logic has taken four bits since reset whose order of arrival is 0, 1, 1, 0. It is 0 in every other cycle.
- R3: Overlapping entries are all detected: the stream 0,1,1,0,1,1,0 raises unlock after the fourth bit and again after the seventh.
- R4: A wrong bit falls back to the longest partial match and not to the start. Examples are 0,1,1,1,0,1,1,0 and 0,1,0,0,1,1,0 and 0,0,1,1,0, each of which unlocks after its last bit.
- R5: `unlock` depends on the state only. A change on `bit_in` between clock edges never changes it.
- R6: With `USE_SYNC` = 1, a bit presented at `bit_in` reaches the state logic two edges later. Both synchronizer stages read 0 after reset, so the state logic takes two 0 bits first. For that reason 1,1,0 presented straight after reset unlocks on this variant and not on the direct one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial code bit, one per clock |
| unlock | output | 1 | High while the last four bits taken were 0,1,1,0 |

## Verification
The bench builds two instances side by side from the same stimulus: one with `USE_SYNC` = 1 and one with `USE_SYNC` = 0. Running both makes the two-cycle latency and the zero contents of the synchronizer after reset observable, because the two instances disagree on a 1,1,0 entry made straight after reset. The direct variant also exposes any combinational path from `bit_in` to `unlock`, since its input changes between the two samples taken in each cycle.

// File: rtl/lock_pkg.sv
// Shared definitions for the serial combination lock.
// Holds the fixed 3-bit state codes and the function that computes one
// lookup-table location from an input bit and a state code.
package lock_pkg;

    localparam int STATE_W = 3;
    localparam int ENTRY_W = STATE_W + 1;
    localparam int ADDR_W  = STATE_W + 1;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [STATE_W-1:0] {
        LK_IDLE = 3'b000,   // nothing useful received yet
        LK_G0   = 3'b001,   // tail "0"
        LK_G01  = 3'b011,   // tail "01"
        LK_G011 = 3'b010,   // tail "011"
        LK_OPEN = 3'b100    // tail "0110": unlocked
    } lock_state_e;

    // Location contents: {next state, unlock of the current state}.
    // Unused codes return to LK_IDLE with unlock 0.
    function automatic logic [ENTRY_W-1:0] lock_entry(input logic b,
                                                      input logic [STATE_W-1:0] s);
        logic [STATE_W-1:0] nxt;
        logic               opn;
        opn = 1'b0;
        case (s)
            LK_IDLE: nxt = b ? LK_IDLE : LK_G0;
            LK_G0:   nxt = b ? LK_G01  : LK_G0;
            LK_G01:  nxt = b ? LK_G011 : LK_G0;
            LK_G011: nxt = b ? LK_IDLE : LK_OPEN;
            LK_OPEN: begin
                nxt = b ? LK_G01 : LK_G0;
                opn = 1'b1;
            end
            default: nxt = LK_IDLE;
        endcase
        return {nxt, opn};
    endfunction

endpackage

// File: rtl/lock_sync.sv
// Input conditioner for the lock.
// With USE_SYNC set, bit_in passes through STAGES flops that are cleared
// by reset. With it clear, bit_in is assumed synchronous and passes
// straight through.
module lock_sync #(
    parameter bit USE_SYNC = 1'b1,
    parameter int STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);

    generate
        if (USE_SYNC) begin : g_sync
            logic [STAGES-1:0] chain_q;

            // Shift the raw bit along the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], bit_in};
            end

            assign bit_out = chain_q[STAGES-1];
        end else begin : g_direct
            assign bit_out = bit_in;
        end
    endgenerate

endmodule

// File: rtl/lock_table.sv
// Next-state and output lookup table, 16 locations by 4 bits.
// Address is {input bit, state}; contents are {next state, unlock}.
// Every location is computed from the package function, so nothing is
// written out by hand.
module lock_table
    import lock_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [ENTRY_W-1:0] data
);

    logic [ENTRY_W-1:0] rom [DEPTH];

    generate
        for (genvar a = 0; a < DEPTH; a++) begin : g_loc
            localparam logic [ADDR_W-1:0] A = ADDR_W'(a);
            assign rom[a] = lock_entry(A[ADDR_W-1], A[STATE_W-1:0]);
        end
    endgenerate

    // Read the addressed location.
    always_comb data = rom[addr];

endmodule

// File: rtl/lock_state_reg.sv
// State register of the lock. A low rst_n at a rising edge loads the
// initial code; otherwise the register takes the table's next state.
module lock_state_reg
    import lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] nxt,
    output logic [STATE_W-1:0] state_q
);

    // Hold the current state code.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= nxt;
    end

endmodule

// File: rtl/combo_lock_fsm.sv
// Serial combination lock, top level.
// Assumes bit_in is synchronous when USE_SYNC is 0. Unlock is taken from
// the table location of the current state, and it is the same for both
// input halves, so it is a function of the state alone.
module combo_lock_fsm
    import lock_pkg::*;
#(
    parameter bit USE_SYNC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic unlock
);

    logic               din;
    logic [STATE_W-1:0] state_q;
    logic [ENTRY_W-1:0] entry;

    lock_sync #(.USE_SYNC(USE_SYNC), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .bit_out (din)
    );

    lock_table u_table (
        .addr (ADDR_W'({din, state_q})),
        .data (entry)
    );

    lock_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt     (entry[ENTRY_W-1:1]),
        .state_q (state_q)
    );

    // Drive the output from the unlock bit of the location.
    always_comb unlock = entry[0];

endmodule

// File: rtl/combo_lock_chk.sv
// Assertion checker for combo_lock_fsm, attached with bind.
// Keeps its own history of the bits taken by the state logic.
module combo_lock_chk #(
    parameter bit USE_SYNC = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_in,
    input logic       din,
    input logic [2:0] state_q,
    input logic       unlock
);

    logic [3:0] hist_q;
    logic [2:0] cnt_q;

    // Record the bits taken since reset and count them up to four.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else begin
            hist_q <= {hist_q[2:0], din};
            if (cnt_q != 3'd4) cnt_q <= cnt_q + 3'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == 3'b000 && !unlock));

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 3'b000 || state_q == 3'b001 || state_q == 3'b011 ||
         state_q == 3'b010 || state_q == 3'b100));

    p_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unlock == (cnt_q == 3'd4 && hist_q == 4'b0110));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> !unlock);

    p_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 3'b100 && din) |=> state_q == 3'b011);

    generate
        if (USE_SYNC) begin : g_lat
            p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q >= 3'd2) |-> din == $past(bit_in, 2));
        end
    endgenerate

endmodule

bind combo_lock_fsm combo_lock_chk #(.USE_SYNC(USE_SYNC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .din     (din),
    .state_q (state_q),
    .unlock  (unlock)
);

// File: tb/tb_combo_lock_fsm.sv
// Scoreboard bench: the driver pushes the expected unlock values of both
// variants, and the monitor pops and compares them after each edge.
module tb_combo_lock_fsm;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic unl_s, unl_r;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    combo_lock_fsm #(.USE_SYNC(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .unlock(unl_s));

    combo_lock_fsm #(.USE_SYNC(1'b0)) dut_raw (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .unlock(unl_r));

    logic  q_s[$];
    logic  q_r[$];
    string q_t[$];

    // Bench-side reference state for each variant.
    logic [3:0] h_s = '0, h_r = '0;
    int         c_s = 0, c_r = 0;
    logic       p1 = 1'b0, p2 = 1'b0;

    task automatic check(input string tag, input string who,
                         input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s unlock actual=%b expected=%b at %0t",
                     tag, who, act, exp, $time);
        end
    endtask

    // Present one bit and reset level at a falling edge; queue expectations.
    task automatic step(input logic b, input logic r, input string tag);
        logic fed;
        @(negedge clk);
        bit_in = b;
        rst_n  = r;
        if (!r) begin
            h_s = '0; h_r = '0; c_s = 0; c_r = 0; p1 = 1'b0; p2 = 1'b0;
            q_s.push_back(1'b0);
            q_r.push_back(1'b0);
        end else begin
            fed = p2; p2 = p1; p1 = b;
            h_s = {h_s[2:0], fed}; c_s++;
            h_r = {h_r[2:0], b};   c_r++;
            q_s.push_back(c_s >= 4 && h_s == 4'b0110);
            q_r.push_back(c_r >= 4 && h_r == 4'b0110);
        end
        q_t.push_back(tag);
    endtask

    task automatic send(input logic [15:0] bits, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b1, tag);
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, "R1");
    endtask

    // Monitor: compare after each edge, and again after the input moved.
    initial begin
        logic  es, er;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (q_s.size() > 0) begin
                es = q_s.pop_front();
                er = q_r.pop_front();
                t  = q_t.pop_front();
                check(t, "sync", unl_s, es);
                check(t, "direct", unl_r, er);
                @(negedge clk);
                #1;
                check("R5", "direct", unl_r, er);
                check("R5", "sync", unl_s, es);
            end
        end
    end

    // Stimulus.
    initial begin
        logic [15:0] lfsr;
        repeat (2) @(posedge clk);
        #2;
        check("R1", "sync", unl_s, 1'b0);
        check("R1", "direct", unl_r, 1'b0);
        do_reset(2);
        // R1: bits presented while reset is held are ignored.
        for (int i = 0; i < 4; i++) step((i == 1 || i == 2), 1'b0, "R1");
        // R6: straight after reset, 1,1,0 completes only on the sync variant.
        send(16'b110, 3, "R6");
        send(16'b0000, 4, "R6");
        // R2: plain entry.
        send(16'b0110, 4, "R2");
        send(16'b1111, 4, "R2");
        // R3: overlapping entries.
        send(16'b0110110, 7, "R3");
        send(16'b1111, 4, "R3");
        // R4: fallback after wrong bits.
        send(16'b01110110, 8, "R4");
        send(16'b0100110, 7, "R4");
        send(16'b00110, 5, "R4");
        send(16'b11110, 5, "R4");
        // R1: reset in the middle of an entry.
        send(16'b011, 3, "R1");
        do_reset(1);
        send(16'b0111, 4, "R1");
        // R2: long pseudo-random stream.
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            step(lfsr[0], 1'b1, "R2");
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    // Finish on completion or on watchdog expiry.
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule